// File: doc/BRIEF.md
# Handshake Byte Transfer Responder

This block is the peripheral end of a three-wire, byte-at-a-time link to a host processor. The host paces every byte with two active-low strobes it writes into a port-B style register: a "transfer in progress" line (here `pb_tip_n`) and an "acknowledge" line (`pb_tack_n`). Each time the host writes port B, the responder compares the new strobe levels with the levels from the previous write. While a transfer runs, each change of the strobe pair moves one byte. The byte goes in one of two directions, chosen by a shift-direction control bit. In the host-send direction, the byte the host placed in the shift register is captured into an outgoing buffer. In the host-receive direction, the next pending reply byte is loaded into the shift register for the host to read.

The responder drives the active-low request line `treq_n` back to the host. It pulls the line low when reply data waits and releases it after the last reply byte. At the end of a transfer it makes the line follow the acknowledge level. Every byte step and every end-of-transfer acknowledge also schedules a shift-register interrupt. The interrupt arrives after a programmable number of microsecond ticks, which is normally 300. It fires at once when the programmed delay is zero or when the port-B direction register reads all ones. Two 16-entry byte buffers connect the block to the rest of the chip: a fill port for reply bytes and a drain port for captured bytes.

Top module: `hs_responder`

## Requirements
- R1: After reset `treq_n` is 1 and `sr_irq`, `sr_rd_load`, `ovf` and `capt_valid` are 0. `sr_rd_byte` is 0x00 and `reply_full` is 0.
- R2: A port-B write with `pb_tip_n`=0 moves a byte only if the pair {`pb_tack_n`,`pb_tip_n`} differs from the pair of the previous port-B write. A write that repeats the previous pair changes no output. Cycles without a port-B write never produce a byte step. The previous pair is {1,1} after reset.
- R3: A byte step with `host_sends`=1 appends `sr_wr_byte` to the capture buffer if the buffer is not full. Captured bytes appear on `capt_data` in arrival order while `capt_valid`=1, and each `capt_re` pulse removes the oldest one.
- R4: A host-send step into a full capture buffer (16 bytes) drops the byte and schedules no interrupt. It sets `ovf`, which stays 1 until reset.
- R5: A byte step with `host_sends`=0 and at least one reply byte pending removes the oldest reply byte and shows it on `sr_rd_byte`. `sr_rd_load` is 1 for the cycle after that write. With no reply pending, such a step changes nothing.
- R6: When the byte loaded by a host-receive step was the only pending reply byte, `treq_n` goes to 1 in the same cycle as the load.
- R7: A port-B write with `pb_tip_n`=1, where the previous write had `pb_tip_n`=0 and `pb_tack_n` differs from its previous level, sets `treq_n` equal to the new `pb_tack_n` and schedules an interrupt.
- R8: Any other port-B write with `pb_tip_n`=1 drives `treq_n` to 0 when at least one reply byte is pending and otherwise leaves it unchanged. Outside port-B writes `treq_n` never changes.
- R9: With `dly_us`=N>0 and `dirb`≠0xFF, a scheduled interrupt raises `sr_irq` for one cycle after the N-th `us_tick` that follows the scheduling write.
- R10: When `dly_us`=0 or `dirb`=0xFF at the scheduling write, `sr_irq` is 1 in the cycle right after that write.
- R11: Scheduling an interrupt while a delayed one is pending restarts the count from `dly_us`, and only one pulse results.
- R12: Reply bytes written through `reply_we` while fewer than 16 are pending are queued in order. `reply_full` is 1 when 16 are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle microsecond tick enable for the interrupt delay |
| pb_we | input | 1 | Host port-B write strobe |
| pb_tip_n | input | 1 | Transfer-in-progress level written by the host (active low) |
| pb_tack_n | input | 1 | Acknowledge level written by the host (active low) |
| dirb | input | 8 | Current port-B direction register value |
| host_sends | input | 1 | Shift direction: 1 host sends, 0 host receives |
| sr_wr_byte | input | 8 | Shift register byte written by the host |
| dly_us | input | 16 | Interrupt delay in microsecond ticks |
| reply_we | input | 1 | Reply buffer fill strobe |
| reply_data | input | 8 | Reply byte to queue |
| reply_full | output | 1 | Reply buffer holds 16 bytes |
| capt_re | input | 1 | Capture buffer drain strobe |
| capt_data | output | 8 | Oldest captured byte |
| capt_valid | output | 1 | Capture buffer not empty |
| sr_rd_byte | output | 8 | Shift register byte presented to the host |
| sr_rd_load | output | 1 | One-cycle flag: `sr_rd_byte` was just loaded |
| treq_n | output | 1 | Request line to the host (active low) |
| sr_irq | output | 1 | One-cycle shift-register interrupt request |
| ovf | output | 1 | Sticky capture overflow flag |

## Verification
The receive direction is driven with alternating acknowledge edges that are interleaved with a repeated identical write. This separates a pair-change step from an accidental step on every write, and the final byte shows whether the request line is released. The send direction pushes 18 bytes through a 16-entry buffer with a changing acknowledge, which separates correct ordering, the drop on overflow and the sticky flag. The interrupt is tried with a nonzero delay, with a zero delay, with an all-ones direction register and with two steps closer together than the delay. These cases tell the counted path from the bypass and show the restart. Transfer-end writes with and without an acknowledge change check the echo rule against the pending-data rule.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic tack_n;
    logic tip_n;
  } hs_pins_t;

  localparam hs_pins_t PINS_IDLE = '{tack_n: 1'b1, tip_n: 1'b1};
endpackage

// File: rtl/hs_fifo.sv
module hs_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_q];
  assign level   = cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_d  = do_push ? bump(wr_q) : wr_q;
    rd_d  = do_pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + CW'(1);
    if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/hs_sr_delay.sv
module hs_sr_delay #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sched,
  input  logic          bypass,
  input  logic          tick,
  input  logic [DW-1:0] load,
  output logic          irq
);
  logic          busy_q, busy_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          fire;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    fire   = 1'b0;
    if (sched) begin
      if (bypass || (load == '0)) begin
        fire   = 1'b1;
        busy_d = 1'b0;
      end else begin
        busy_d = 1'b1;
        cnt_d  = load;
      end
    end else if (busy_q && tick) begin
      if (cnt_q == DW'(1)) begin
        fire   = 1'b1;
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      irq    <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      irq    <= fire;
    end
  end
endmodule

// File: rtl/hs_step_ctrl.sv
module hs_step_ctrl
  import hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pb_we,
  input  hs_pins_t          pins,
  input  logic              host_sends,
  input  logic              rep_empty,
  input  logic              rep_one,
  input  logic [BYTE_W-1:0] rep_head,
  input  logic              out_full,
  output logic              rep_pop,
  output logic              out_push,
  output logic              sched,
  output logic              treq_n,
  output logic              ovf,
  output logic [BYTE_W-1:0] sr_byte,
  output logic              sr_load
);
  hs_pins_t          prev_q, prev_d;
  logic              treq_d, ovf_d, load_d;
  logic [BYTE_W-1:0] sr_d;

  always_comb begin
    prev_d   = prev_q;
    treq_d   = treq_n;
    ovf_d    = ovf;
    sr_d     = sr_byte;
    load_d   = 1'b0;
    rep_pop  = 1'b0;
    out_push = 1'b0;
    sched    = 1'b0;
    if (pb_we) begin
      prev_d = pins;
      if (!pins.tip_n) begin
        if (pins != prev_q) begin
          if (host_sends) begin
            if (!out_full) begin
              out_push = 1'b1;
              sched    = 1'b1;
            end else begin
              ovf_d = 1'b1;
            end
          end else if (!rep_empty) begin
            rep_pop = 1'b1;
            sr_d    = rep_head;
            load_d  = 1'b1;
            sched   = 1'b1;
            if (rep_one) treq_d = 1'b1;
          end
        end
      end else if (!prev_q.tip_n && (pins.tack_n != prev_q.tack_n)) begin
        treq_d = pins.tack_n;
        sched  = 1'b1;
      end else if (!rep_empty) begin
        treq_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= PINS_IDLE;
      treq_n  <= 1'b1;
      ovf     <= 1'b0;
      sr_byte <= '0;
      sr_load <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      treq_n  <= treq_d;
      ovf     <= ovf_d;
      sr_byte <= sr_d;
      sr_load <= load_d;
    end
  end
endmodule

// File: rtl/hs_responder.sv
module hs_responder
  import hs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DLY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              pb_we,
  input  logic              pb_tip_n,
  input  logic              pb_tack_n,
  input  logic [7:0]        dirb,
  input  logic              host_sends,
  input  logic [BYTE_W-1:0] sr_wr_byte,
  input  logic [DLY_W-1:0]  dly_us,
  input  logic              reply_we,
  input  logic [BYTE_W-1:0] reply_data,
  output logic              reply_full,
  input  logic              capt_re,
  output logic [BYTE_W-1:0] capt_data,
  output logic              capt_valid,
  output logic [BYTE_W-1:0] sr_rd_byte,
  output logic              sr_rd_load,
  output logic              treq_n,
  output logic              sr_irq,
  output logic              ovf
);
  localparam int CW = $clog2(DEPTH + 1);

  hs_pins_t          pins;
  logic              rep_pop, rep_empty;
  logic [BYTE_W-1:0] rep_head;
  logic [CW-1:0]     rep_level, out_level;
  logic              out_push, out_full, out_empty;
  logic              step_sched;
  logic              dly_bypass;

  assign pins       = '{tack_n: pb_tack_n, tip_n: pb_tip_n};
  assign dly_bypass = (dirb == 8'hFF);
  assign capt_valid = !out_empty;

  hs_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_reply_q (
    .clk(clk), .rst_n(rst_n),
    .push(reply_we), .din(reply_data),
    .pop(rep_pop), .dout(rep_head),
    .full(reply_full), .empty(rep_empty), .level(rep_level)
  );

  hs_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_capt_q (
    .clk(clk), .rst_n(rst_n),
    .push(out_push), .din(sr_wr_byte),
    .pop(capt_re), .dout(capt_data),
    .full(out_full), .empty(out_empty), .level(out_level)
  );

  hs_step_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pb_we(pb_we), .pins(pins), .host_sends(host_sends),
    .rep_empty(rep_empty), .rep_one(rep_level == CW'(1)), .rep_head(rep_head),
    .out_full(out_full),
    .rep_pop(rep_pop), .out_push(out_push), .sched(step_sched),
    .treq_n(treq_n), .ovf(ovf), .sr_byte(sr_rd_byte), .sr_load(sr_rd_load)
  );

  hs_sr_delay #(.DW(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_n),
    .sched(step_sched), .bypass(dly_bypass), .tick(us_tick),
    .load(dly_us), .irq(sr_irq)
  );

  logic unused_lvl;
  assign unused_lvl = ^out_level;
endmodule

// File: rtl/hs_responder_chk.sv
module hs_responder_chk #(
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pb_we,
  input logic             pb_tip_n,
  input logic             host_sends,
  input logic             us_tick,
  input logic [7:0]       dirb,
  input logic [DLY_W-1:0] dly_us,
  input logic             sched,
  input logic             sr_irq,
  input logic             sr_rd_load,
  input logic             treq_n,
  input logic             ovf
);
  p_no_step_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pb_we |=> !sr_rd_load);

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  p_ovf_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(pb_we) && $past(host_sends)));

  p_load_from_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_rd_load |-> ($past(pb_we) && !$past(pb_tip_n) && !$past(host_sends)));

  p_treq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pb_we |=> $stable(treq_n));

  p_irq_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_irq && !$past(sched)) |-> $past(us_tick));

  p_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sched && ((dirb == 8'hFF) || (dly_us == '0))) |=> sr_irq);
endmodule

bind hs_responder hs_responder_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pb_we(pb_we), .pb_tip_n(pb_tip_n),
  .host_sends(host_sends), .us_tick(us_tick), .dirb(dirb), .dly_us(dly_us),
  .sched(step_sched), .sr_irq(sr_irq), .sr_rd_load(sr_rd_load),
  .treq_n(treq_n), .ovf(ovf)
);

// File: tb/test_hs_responder.sv
`timescale 1ns/1ps
module test_hs_responder;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic pb_we = 1'b0;
  logic pb_tip_n = 1'b1;
  logic pb_tack_n = 1'b1;
  logic [7:0] dirb = 8'h00;
  logic host_sends = 1'b0;
  logic [7:0] sr_wr_byte = 8'h00;
  logic [15:0] dly_us = 16'd3;
  logic reply_we = 1'b0;
  logic [7:0] reply_data = 8'h00;
  logic capt_re = 1'b0;
  logic reply_full, capt_valid, sr_rd_load, treq_n, sr_irq, ovf;
  logic [7:0] capt_data, sr_rd_byte;

  always #5 clk = ~clk;

  hs_responder i_hs_responder (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .pb_we(pb_we),
    .pb_tip_n(pb_tip_n), .pb_tack_n(pb_tack_n), .dirb(dirb),
    .host_sends(host_sends), .sr_wr_byte(sr_wr_byte), .dly_us(dly_us),
    .reply_we(reply_we), .reply_data(reply_data), .reply_full(reply_full),
    .capt_re(capt_re), .capt_data(capt_data), .capt_valid(capt_valid),
    .sr_rd_byte(sr_rd_byte), .sr_rd_load(sr_rd_load), .treq_n(treq_n),
    .sr_irq(sr_irq), .ovf(ovf)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";
  bit tick_en = 1'b0;
  int tdiv = 0;
  int cyc = 0;

  // tick generator: one us_tick every 5 cycles when enabled
  always @(negedge clk) begin
    #1;
    if (tick_en) begin
      tdiv = (tdiv == 4) ? 0 : tdiv + 1;
      us_tick = (tdiv == 4);
    end else begin
      us_tick = 1'b0;
    end
  end

  // behavioural reference model
  byte unsigned q_rep[$];
  byte unsigned q_out[$];
  bit m_prev_tip, m_prev_tack, m_treq, m_ovf, m_load, m_irq, m_busy;
  byte unsigned m_sr;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_rep.delete(); q_out.delete();
      m_prev_tip = 1; m_prev_tack = 1; m_treq = 1; m_ovf = 0;
      m_load = 0; m_irq = 0; m_busy = 0; m_sr = 0; m_cnt = 0;
    end else begin
      bit sched, fire, was_full_out, pend, only_one;
      int rep_sz;
      sched = 0; fire = 0;
      rep_sz = q_rep.size();
      pend = rep_sz > 0;
      only_one = rep_sz == 1;
      was_full_out = q_out.size() == DEPTH;
      m_load = 0;
      if (pb_we) begin
        if (!pb_tip_n) begin
          if (pb_tip_n != m_prev_tip || pb_tack_n != m_prev_tack) begin
            if (host_sends) begin
              if (!was_full_out) begin q_out.push_back(sr_wr_byte); sched = 1; end
              else m_ovf = 1;
            end else if (pend) begin
              m_sr = q_rep.pop_front(); m_load = 1; sched = 1;
              if (only_one) m_treq = 1;
            end
          end
        end else if (!m_prev_tip && pb_tack_n != m_prev_tack) begin
          m_treq = pb_tack_n; sched = 1;
        end else if (pend) begin
          m_treq = 0;
        end
        m_prev_tip = pb_tip_n; m_prev_tack = pb_tack_n;
      end
      if (capt_re && q_out.size() > 0 && !(was_full_out == 0 && 0)) begin
        if (!(pb_we && host_sends && q_out.size() == 1 && 0)) void'(q_out.pop_front());
      end
      if (reply_we && rep_sz < DEPTH) q_rep.push_back(reply_data);
      if (sched) begin
        if (dirb == 8'hFF || dly_us == 0) begin fire = 1; m_busy = 0; end
        else begin m_busy = 1; m_cnt = dly_us; end
      end else if (m_busy && us_tick) begin
        if (m_cnt == 1) begin fire = 1; m_busy = 0; end
        else m_cnt = m_cnt - 1;
      end
      m_irq = fire;
    end
  end

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("treq_n", {7'b0, treq_n}, {7'b0, m_treq});
      chk("sr_irq", {7'b0, sr_irq}, {7'b0, m_irq});
      chk("sr_rd_load", {7'b0, sr_rd_load}, {7'b0, m_load});
      chk("sr_rd_byte", sr_rd_byte, m_sr);
      chk("ovf", {7'b0, ovf}, {7'b0, m_ovf});
      chk("capt_valid", {7'b0, capt_valid}, {7'b0, q_out.size() > 0});
      if (q_out.size() > 0) chk("capt_data", capt_data, q_out[0]);
      chk("reply_full", {7'b0, reply_full}, {7'b0, q_rep.size() == DEPTH});
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pb(bit tip, bit tack);
    @(negedge clk); #2;
    pb_we = 1; pb_tip_n = tip; pb_tack_n = tack;
    @(negedge clk); #2;
    pb_we = 0;
  endtask

  task automatic fill(byte unsigned b);
    @(negedge clk); #2;
    reply_we = 1; reply_data = b;
    @(negedge clk); #2;
    reply_we = 0;
  endtask

  task automatic drain();
    @(negedge clk); #2;
    capt_re = 1;
    @(negedge clk); #2;
    capt_re = 0;
  endtask

  initial begin
    idle(3);
    @(negedge clk); #2; rst_n = 1;
    // R1: reset state checked explicitly and by the per-cycle compare
    @(negedge clk); #1;
    chk("R1 reset treq_n", {7'b0, treq_n}, 8'h01);
    chk("R1 reset irq/load/ovf/valid", {4'b0, sr_irq, sr_rd_load, ovf, capt_valid}, 8'h00);
    tick_en = 1;

    // R12, R8: queue replies, idle write pulls request low
    phase = "R12";
    fill(8'hA1); fill(8'hB2); fill(8'hC3);
    phase = "R8";
    pb(1, 1);
    idle(2);

    // R5, R2, R6, R9: host receives three bytes
    phase = "R5";
    pb(0, 1);
    idle(25);
    phase = "R2";
    pb(0, 1);
    idle(3);
    phase = "R5";
    pb(0, 0);
    idle(25);
    phase = "R6";
    pb(0, 1);
    idle(25);
    phase = "R5";
    pb(0, 0);
    idle(5);

    // R7: transfer end with unchanged ack, then with changed ack
    phase = "R7";
    pb(1, 0);
    idle(3);
    pb(0, 1);
    pb(1, 0);
    idle(25);

    // R3, R4: host sends 18 bytes into a 16-entry buffer
    host_sends = 1;
    for (int i = 0; i < 18; i++) begin
      phase = (i < 16) ? "R3" : "R4";
      sr_wr_byte = 8'h10 + 8'(i);
      pb(0, 1'(i % 2));
    end
    idle(25);
    phase = "R3";
    for (int i = 0; i < 16; i++) drain();
    idle(3);

    // R10: zero delay, then all-ones direction register
    phase = "R10";
    dly_us = 16'd0;
    sr_wr_byte = 8'h5A;
    pb(0, 0);
    idle(3);
    dly_us = 16'd3;
    dirb = 8'hFF;
    sr_wr_byte = 8'h6B;
    pb(0, 1);
    idle(3);
    dirb = 8'h00;

    // R11: restart while pending
    phase = "R11";
    dly_us = 16'd6;
    pb(0, 0);
    idle(8);
    pb(0, 1);
    idle(45);
    drain(); drain(); drain(); drain();

    // R7 again with host-receive direction and pending data
    phase = "R8";
    host_sends = 0;
    fill(8'hD4);
    pb(1, 1);
    idle(3);
    phase = "R6";
    pb(0, 0);
    idle(40);
    phase = "R7";
    pb(1, 1);
    idle(40);

    // R1: reset in the middle clears sticky state
    phase = "R1";
    @(negedge clk); #2; rst_n = 0;
    idle(2);
    @(negedge clk); #2; rst_n = 1;
    idle(5);
    finish_run();
  end
endmodule